// File: doc/BRIEF.md
# Clock Failure Monitor

This block watches a bus clock from a separate free-running reference clock and forces a system reset when the bus clock halts or slows too far. Every rising edge of the monitored clock flips a toggle flop. The toggle is carried into the reference domain through a synchronizer chain. Each transition seen there clears an interval counter. If the counter reaches `TRIP_TICKS` reference cycles without a new edge, the block reports a failure.

The trip point has a permitted band: no trip while the bus clock is above 200 kHz, and a guaranteed trip below 10 kHz. The bus clock is one quarter of the crystal frequency. With a 1 MHz reference and the default of 20 ticks, the trip point lands near 50 kHz, well inside that band.

On a failure, the block drives a short active-low reset request lasting `PULSE_CYCLES` reference cycles, which is shorter than four bus cycles. It also latches a cause flag that tells a clock-failure reset apart from a watchdog reset. The monitor is enabled by a plain enable bit or by a force bit. The force bit is sticky until system reset. A clock that is stopped on purpose for low-power operation counts as a failure whenever the monitor is enabled.

Top module: `clk_fail_monitor`

## Requirements
- R1: After system reset is released, the reset request output is high and the cause flag is low.
- R2: While the monitor is enabled, a monitored clock whose rising edges are no more than `TRIP_TICKS`-4 reference cycles apart never produces a reset request.
- R3: While the monitor is enabled, a stopped monitored clock, or one with rising edges `2*TRIP_TICKS` reference cycles apart, produces a reset request. The request begins no sooner than `TRIP_TICKS` reference cycles after the last rising edge.
- R4: The reset request is active low and lasts exactly `PULSE_CYCLES` reference cycles (default 3).
- R5: The cause flag goes high in the same cycle the reset request starts. It stays high until system reset, even if the monitored clock resumes. No second reset request is produced before system reset.
- R6: With the enable low and the force bit never set, a stopped monitored clock produces no reset request and leaves the cause flag low.
- R7: The enable may be cleared at any time while the force bit is unset. Clearing it discards the interval count, so after re-enabling, a trip needs a full `TRIP_TICKS` further cycles with no edge.
- R8: A force-enable input held high for a single reference cycle keeps the monitor enabled until system reset, whatever the enable input does afterwards.
- R9: System reset clears the force-enable latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock that times the monitor |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| mon_clk | input | 1 | Monitored bus clock |
| mon_en | input | 1 | Monitor enable, sampled on ref_clk |
| force_en | input | 1 | Force-enable; a high sample latches the enable until reset |
| rst_req_n | output | 1 | Active-low reset request pulse |
| clk_fail_cause | output | 1 | Latched flag marking a clock-failure reset |

## Verification
The hardest state to reach from the ports is a re-enable that follows a partial count. The interval counter must forget the time it had already spent with no edge. The bench holds the monitored clock stopped, enables the monitor for part of the trip interval, drops the enable, and then raises it again. It then measures the number of reference cycles from re-enable to the falling edge of the request. The sticky force path is driven with a single-cycle force pulse while the plain enable stays low, and is then cleared by a system reset.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  // Default reference ticks without a monitored edge before a trip.
  localparam int unsigned DEF_TRIP_TICKS   = 20;
  // Default length of the active-low reset request, in reference cycles.
  localparam int unsigned DEF_PULSE_CYCLES = 3;
  // Default depth of the edge synchronizer.
  localparam int unsigned DEF_SYNC_STAGES  = 2;
endpackage

// File: rtl/clkmon_rst_sync.sv
module clkmon_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic mon_clk_i,
  input  logic mon_rst_ni,
  input  logic ref_clk_i,
  input  logic ref_rst_ni,
  output logic edge_o
);
  // Toggle flop in the monitored domain: flips on every rising edge.
  logic tog_q;
  logic tog_d;

  always_comb tog_d = ~tog_q;

  always_ff @(posedge mon_clk_i or negedge mon_rst_ni) begin
    if (!mon_rst_ni) tog_q <= 1'b0;
    else             tog_q <= tog_d;
  end

  // Synchronizer chain in the reference domain, plus one history stage.
  logic [STAGES:0] sync_q;
  logic [STAGES:0] sync_d;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb sync_d[g] = tog_q;
      end else begin : g_next
        always_comb sync_d[g] = sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge ref_clk_i or negedge ref_rst_ni) begin
    if (!ref_rst_ni) sync_q <= '0;
    else             sync_q <= sync_d;
  end

  assign edge_o = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/clkmon_interval.sv
module clkmon_interval #(
  parameter int unsigned TRIP_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_en_i,
  input  logic force_en_i,
  input  logic edge_i,
  input  logic halt_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(TRIP_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TRIP_TICKS - 1);

  logic          force_q, force_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_eff;

  always_comb begin
    force_d = force_q | force_en_i;
    en_eff  = mon_en_i | force_q;
    cnt_d   = cnt_q;
    if (!en_eff || halt_i || edge_i) cnt_d = '0;
    else if (cnt_q != LAST)          cnt_d = cnt_q + 1'b1;
    trip_o  = en_eff & ~halt_i & ~edge_i & (cnt_q == LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      force_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      force_q <= force_d;
      cnt_q   <= cnt_d;
    end
  end

  // R8: once latched, force-enable stays set until reset.
  assert_force_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_q |=> force_q);
endmodule

// File: rtl/clkmon_reset_pulse.sv
module clkmon_reset_pulse #(
  parameter int unsigned PULSE_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  output logic rst_req_no,
  output logic cause_o
);
  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_CYCLES);

  logic          cause_q, cause_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    cause_d = cause_q;
    pcnt_d  = pcnt_q;
    if (trip_i && !cause_q) begin
      cause_d = 1'b1;
      pcnt_d  = PLEN;
    end else if (pcnt_q != '0) begin
      pcnt_d = pcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      cause_q <= cause_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign rst_req_no = (pcnt_q == '0);
  assign cause_o    = cause_q;

  assert_cause_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_q |=> cause_q);
  assert_req_implies_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_req_no |-> cause_q);
  assert_cause_starts_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_q) |-> !rst_req_no);
  assert_single_trip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_q |-> !trip_i);
endmodule

// File: rtl/clk_fail_monitor.sv
module clk_fail_monitor
  import clkmon_pkg::*;
#(
  parameter int unsigned TRIP_TICKS   = DEF_TRIP_TICKS,
  parameter int unsigned PULSE_CYCLES = DEF_PULSE_CYCLES,
  parameter int unsigned SYNC_STAGES  = DEF_SYNC_STAGES
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_clk,
  input  logic mon_en,
  input  logic force_en,
  output logic rst_req_n,
  output logic clk_fail_cause
);
  logic ref_rst_n;
  logic edge_seen;
  logic trip;
  logic cause;

  clkmon_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i(ref_clk), .rst_ni(rst_n), .rst_sync_no(ref_rst_n)
  );

  clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_edge_sync (
    .mon_clk_i(mon_clk), .mon_rst_ni(rst_n),
    .ref_clk_i(ref_clk), .ref_rst_ni(ref_rst_n),
    .edge_o(edge_seen)
  );

  clkmon_interval #(.TRIP_TICKS(TRIP_TICKS)) u_interval (
    .clk_i(ref_clk), .rst_ni(ref_rst_n),
    .mon_en_i(mon_en), .force_en_i(force_en),
    .edge_i(edge_seen), .halt_i(cause), .trip_o(trip)
  );

  clkmon_reset_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i(ref_clk), .rst_ni(ref_rst_n), .trip_i(trip),
    .rst_req_no(rst_req_n), .cause_o(cause)
  );

  assign clk_fail_cause = cause;
endmodule

// File: tb/clk_fail_monitor_tb.sv
module clk_fail_monitor_tb;
  localparam int TRIP  = 20;
  localparam int PLEN  = 3;

  logic ref_clk = 1'b0;
  logic rst_n;
  logic mon_clk = 1'b0;
  logic mon_en;
  logic force_en;
  logic rst_req_n;
  logic clk_fail_cause;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;
  bit  mon_run  = 0;
  int  mon_half = 60;

  int  cyc = 0;
  int  pulses = 0;
  int  fall_cyc = 0;
  int  low_run = 0;
  int  last_len = 0;
  logic prev_req = 1'b1;

  clk_fail_monitor #(.TRIP_TICKS(TRIP), .PULSE_CYCLES(PLEN), .SYNC_STAGES(2)) u_dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .mon_en(mon_en),
    .force_en(force_en), .rst_req_n(rst_req_n), .clk_fail_cause(clk_fail_cause)
  );

  always #10 ref_clk = ~ref_clk;

  always begin
    if (mon_run) #(mon_half) mon_clk = ~mon_clk;
    else #5;
  end

  // Observe the request pulse between clock edges.
  always @(negedge ref_clk) begin
    cyc <= cyc + 1;
    if (prev_req && !rst_req_n) begin
      pulses   <= pulses + 1;
      fall_cyc <= cyc;
    end
    if (!prev_req && rst_req_n) last_len <= low_run;
    low_run  <= rst_req_n ? 0 : low_run + 1;
    prev_req <= rst_req_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic do_reset();
    @(negedge ref_clk);
    rst_n = 1'b0; mon_en = 1'b0; force_en = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    pulses = 0;
  endtask

  task automatic t_reset_state();
    mon_run = 0;
    do_reset();
    check(rst_req_n == 1'b1, "R1 req", rst_req_n, 1);
    check(clk_fail_cause == 1'b0, "R1 cause", clk_fail_cause, 0);
  endtask

  task automatic t_fast_clock();
    do_reset();
    mon_half = 60; mon_run = 1;
    wait_cyc(10);
    mon_en = 1'b1;
    wait_cyc(300);
    check(pulses == 0, "R2 fast pulses", pulses, 0);
    mon_half = 160;  // edges 16 ref cycles apart
    wait_cyc(400);
    check(pulses == 0, "R2 edge-limit pulses", pulses, 0);
    check(clk_fail_cause == 1'b0, "R2 cause", clk_fail_cause, 0);
  endtask

  task automatic t_stop_trips();
    int stop_c;
    mon_half = 60;
    wait_cyc(20);
    mon_run = 0;
    stop_c = cyc;
    wait_cyc(TRIP + 20);
    check(pulses == 1, "R3 stop pulses", pulses, 1);
    check(fall_cyc - stop_c >= TRIP && fall_cyc - stop_c <= TRIP + 12,
          "R3 latency", fall_cyc - stop_c, TRIP);
    check(last_len == PLEN, "R4 pulse length", last_len, PLEN);
    check(clk_fail_cause == 1'b1, "R5 cause set", clk_fail_cause, 1);
  endtask

  task automatic t_resume_holds();
    mon_run = 1;
    wait_cyc(200);
    check(clk_fail_cause == 1'b1, "R5 cause held", clk_fail_cause, 1);
    check(pulses == 1, "R5 no second pulse", pulses, 1);
    mon_run = 0;
    wait_cyc(100);
    check(pulses == 1, "R5 no retrip", pulses, 1);
  endtask

  task automatic t_slow_clock();
    do_reset();
    mon_half = 400; mon_run = 1;  // edges 40 ref cycles apart
    mon_en = 1'b1;
    wait_cyc(200);
    check(pulses == 1, "R3 slow clock pulses", pulses, 1);
    check(clk_fail_cause == 1'b1, "R3 slow clock cause", clk_fail_cause, 1);
    mon_run = 0;
    mon_half = 60;
  endtask

  task automatic t_disabled();
    do_reset();
    wait_cyc(100);
    check(pulses == 0, "R6 disabled pulses", pulses, 0);
    check(clk_fail_cause == 1'b0, "R6 disabled cause", clk_fail_cause, 0);
  endtask

  task automatic t_reenable();
    int en_c;
    do_reset();
    mon_en = 1'b1;
    wait_cyc(TRIP - 6);
    mon_en = 1'b0;
    wait_cyc(5);
    check(pulses == 0, "R7 no trip while off", pulses, 0);
    mon_en = 1'b1;
    en_c = cyc;
    wait_cyc(TRIP + 10);
    check(pulses == 1, "R7 trip after re-enable", pulses, 1);
    check(fall_cyc - en_c >= TRIP && fall_cyc - en_c <= TRIP + 3,
          "R7 full interval", fall_cyc - en_c, TRIP);
  endtask

  task automatic t_force();
    do_reset();
    force_en = 1'b1;
    wait_cyc(1);
    force_en = 1'b0;
    mon_en = 1'b0;
    wait_cyc(TRIP + 20);
    check(pulses == 1, "R8 forced trip", pulses, 1);
    check(clk_fail_cause == 1'b1, "R8 forced cause", clk_fail_cause, 1);
  endtask

  task automatic t_force_cleared();
    do_reset();
    wait_cyc(100);
    check(pulses == 0, "R9 force cleared pulses", pulses, 0);
    check(clk_fail_cause == 1'b0, "R9 force cleared cause", clk_fail_cause, 0);
  endtask

  initial begin
    rst_n = 1'b0; mon_en = 1'b0; force_en = 1'b0;
    t_reset_state();
    t_fast_clock();
    t_stop_trips();
    t_resume_holds();
    t_slow_clock();
    t_disabled();
    t_reenable();
    t_force();
    t_force_cleared();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(2_000_000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule